// File: doc/BRIEF.md
# Write Combining Buffer with Idle Timeout

This block sits between a single-beat AHB write master and a memory-side AXI write channel. Small writes that land in the same aligned line are merged, byte by byte, into a local line store. The line then leaves as one incrementing burst whose write strobes mark only the bytes that were actually written. A line goes out as soon as every byte is valid. A line that stays partly filled goes out when a 10-bit idle counter reaches a programmed limit. A write that needs the buffer while a different line is held forces that line out first.

Two mechanisms let a write bypass merging and go out as its own single-beat burst. The first is an address window of power-of-two size, matched on the upper address bits. The second is a per-master enable bit. The flush does not drive the bus on its own initiative. It raises a request towards an external arbiter and waits for a grant. It may raise that request only when the write response for the previous burst has come back.

Top module: `wcb_top`

## Requirements
- R1: A combined line leaves as one AXI burst with awburst=2'b01 (incrementing) and awsize=3'd2 (4-byte beats). awaddr is the line-aligned address. awlen is 3 when cfg_line32=0 (16-byte line) and 7 when cfg_line32=1 (32-byte line). Beat k carries the word at line offset 4*k.
- R2: Write strobes follow hsize and haddr[1:0]. hsize=0 sets one lane, at haddr[1:0]. hsize=1 sets lanes 1:0 when haddr[1]=0 and lanes 3:2 otherwise. hsize=2 sets all four lanes. Each beat's wstrb is the OR of the lanes written to that word. Bytes with no strobe set are never reported as written.
- R3: The idle counter returns to zero on every write merged into the line and stays at zero while the buffer is empty. After the last merged write, flush_req rises exactly cfg_timeout+1 clock edges after the edge that accepted that write, provided no response is outstanding.
- R4: A line whose bytes are all valid is flushed immediately, without waiting for the timeout.
- R5: flush_req is never high while a burst's write response is still outstanding. Once raised, it stays high until flush_gnt is seen.
- R6: A combinable write to a different line than the one held drives hready low. The held line is then flushed, and the new write is accepted into the emptied buffer afterwards.
- R7: Let N = cfg_nb_size, where N=0 disables the window. A write is in the window when cfg_nb_base[15:N-1] equals haddr[31:N+15]. Such a write first flushes any held line. It then leaves as a single burst with awlen=0 and awaddr equal to the word-aligned address.
- R8: When cfg_comb_en[hmaster] is 0, the write is not combined and is handled as a single-beat burst, exactly as in R7.
- R9: After reset, hready=1, flush_req=0, awvalid=0 and wvalid=0.
- R10: A later write to a byte already held in the line replaces that byte's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel | input | 1 | AHB slave select |
| haddr | input | 32 | AHB address |
| htrans | input | 2 | AHB transfer type (bit 1 set = active) |
| hwrite | input | 1 | AHB write |
| hsize | input | 3 | AHB size: 0 byte, 1 halfword, 2 word |
| hwdata | input | 32 | AHB write data (data phase) |
| hmaster | input | 2 | Master number, used to select the combine enable |
| hready | output | 1 | AHB ready; low stalls the data phase |
| cfg_timeout | input | 10 | Idle timeout limit in cycles |
| cfg_line32 | input | 1 | 1 = 32-byte line, 0 = 16-byte line |
| cfg_nb_base | input | 16 | Window base, compared with haddr[31:16] |
| cfg_nb_size | input | 4 | Window size code N; 0 = window off |
| cfg_comb_en | input | 4 | Per-master combine enable |
| flush_req | output | 1 | Flush request to arbiter |
| flush_gnt | input | 1 | Flush grant from arbiter |
| awvalid | output | 1 | AXI write address valid |
| awready | input | 1 | AXI write address ready |
| awaddr | output | 32 | Burst start address |
| awlen | output | 8 | Beats minus one |
| awsize | output | 3 | Beat size code (always 2) |
| awburst | output | 2 | Burst type (always incrementing) |
| wvalid | output | 1 | AXI write data valid |
| wready | input | 1 | AXI write data ready |
| wdata | output | 32 | Write data beat |
| wstrb | output | 4 | Byte strobes of the beat |
| wlast | output | 1 | Last beat of burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |

## Verification
Lines are filled in ascending word order, in descending order, and with mixed byte and halfword writes that overlap. This separates the lane and strobe mapping, beat ordering, last-write-wins merging and the full-line trigger. A line left partly filled, with a deliberate pause between its writes, pins down the exact timeout latency and shows that the counter restarts on each write. Back-to-back writes to two different lines, writes just inside and just outside two window sizes, and writes from a master with combining disabled interleaved with combining masters separate the three flush causes from one another. A slow write response shows whether the request waits for it.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_REQ  = 2'd1,
        FL_ADDR = 2'd2,
        FL_DATA = 2'd3
    } flush_state_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [2:0]  size;
    } wr_phase_t;

    // byte lanes touched by one AHB transfer on a 32-bit bus
    function automatic logic [STRB_W-1:0] lane_strobe(input logic [1:0] lo, input logic [2:0] size);
        case (size)
            3'd0:    lane_strobe = 4'b0001 << lo;
            3'd1:    lane_strobe = lo[1] ? 4'b1100 : 4'b0011;
            default: lane_strobe = 4'b1111;
        endcase
    endfunction

    // which of the 16 upper base bits take part in the window compare
    function automatic logic [15:0] window_mask(input logic [3:0] n);
        window_mask = 16'hFFFF << (n - 4'd1);
    endfunction

endpackage

// File: rtl/wcb_nb_match.sv
module wcb_nb_match
    import wcb_pkg::*;
(
    input  logic [31:0] addr,
    input  logic [15:0] base,
    input  logic [3:0]  size_n,
    output logic        hit
);
    logic [15:0] mask;

    always_comb begin
        mask = window_mask(size_n);
        hit  = (size_n != 4'd0) && (((addr[31:16] ^ base) & mask) == 16'h0000);
    end
endmodule

// File: rtl/wcb_timeout.sv
module wcb_timeout #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         hit
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            count <= '0;
        else if (run && count != limit)
            count <= count + 1'b1;
    end

    assign hit = run && (count == limit);
endmodule

// File: rtl/wcb_line_store.sv
module wcb_line_store
    import wcb_pkg::*;
#(
    parameter int WORDS = 8,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wide,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    output logic [STRB_W-1:0] rstrb,
    output logic              full
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [STRB_W-1:0] bv  [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || clr)
                bv[w] <= '0;
            else if (we && widx == IDX_W'(w))
                bv[w] <= bv[w] | wstrb;
        end

        always_ff @(posedge clk) begin
            if (we && widx == IDX_W'(w)) begin
                for (int b = 0; b < STRB_W; b++)
                    if (wstrb[b])
                        mem[w][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    always_comb begin
        full = 1'b1;
        for (int i = 0; i < WORDS; i++)
            if (wide || i < WORDS / 2)
                full = full & (&bv[i]);
    end

    assign rdata = mem[ridx];
    assign rstrb = bv[ridx];
endmodule

// File: rtl/wcb_flush_ctl.sv
module wcb_flush_ctl
    import wcb_pkg::*;
#(
    parameter int WORDS = 8,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trigger,
    input  logic              gnt,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              awready,
    input  logic              wready,
    input  logic              bvalid,
    input  logic [DATA_W-1:0] rdata,
    input  logic [STRB_W-1:0] rstrb,
    output logic              flush_req,
    output logic              busy,
    output logic              done,
    output logic              b_out,
    output logic              awvalid,
    output logic              wvalid,
    output logic [DATA_W-1:0] wdata,
    output logic [STRB_W-1:0] wstrb,
    output logic              wlast,
    output logic              bready,
    output logic [IDX_W-1:0]  ridx
);
    flush_state_e state;
    logic [IDX_W-1:0] beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FL_IDLE;
            beat  <= '0;
        end else begin
            case (state)
                FL_IDLE: if (trigger && !b_out) state <= FL_REQ;
                FL_REQ:  if (gnt) state <= FL_ADDR;
                FL_ADDR: if (awready) begin
                    state <= FL_DATA;
                    beat  <= '0;
                end
                FL_DATA: if (wready) begin
                    if (beat == last_idx) state <= FL_IDLE;
                    else                  beat  <= beat + 1'b1;
                end
                default: state <= FL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            b_out <= 1'b0;
        else if (done)
            b_out <= 1'b1;
        else if (bvalid)
            b_out <= 1'b0;
    end

    assign flush_req = (state == FL_REQ);
    assign busy      = (state != FL_IDLE);
    assign awvalid   = (state == FL_ADDR);
    assign wvalid    = (state == FL_DATA);
    assign wlast     = wvalid && (beat == last_idx);
    assign done      = wlast && wready;
    assign ridx      = beat;
    assign wdata     = rdata;
    assign wstrb     = rstrb;
    assign bready    = 1'b1;
endmodule

// File: rtl/wcb_top.sv
module wcb_top
    import wcb_pkg::*;
#(
    parameter int LINE_WORDS = 8,
    parameter int NUM_MST    = 4,
    parameter int TMO_W      = 10,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int MST_W     = $clog2(NUM_MST),
    localparam int LINE_B    = LINE_WORDS * STRB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsel,
    input  logic [31:0]       haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    input  logic [MST_W-1:0]  hmaster,
    output logic              hready,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic              cfg_line32,
    input  logic [15:0]       cfg_nb_base,
    input  logic [3:0]        cfg_nb_size,
    input  logic [NUM_MST-1:0] cfg_comb_en,
    output logic              flush_req,
    input  logic              flush_gnt,
    output logic              awvalid,
    input  logic              awready,
    output logic [31:0]       awaddr,
    output logic [7:0]        awlen,
    output logic [2:0]        awsize,
    output logic [1:0]        awburst,
    output logic              wvalid,
    input  logic              wready,
    output logic [DATA_W-1:0] wdata,
    output logic [STRB_W-1:0] wstrb,
    output logic              wlast,
    input  logic              bvalid,
    output logic              bready
);
    // data-phase register
    wr_phase_t        dp;
    logic             dp_valid;
    logic [MST_W-1:0] dp_mst;

    // held line
    logic        line_valid;
    logic        line_single;
    logic [31:0] line_base;

    logic        nb_hit, bypass, match, full, can_take, accept, trigger;
    logic        busy, done, b_out, tmo_hit;
    logic [TMO_W-1:0] tmo_cnt;
    logic [31:0] align;
    logic [IDX_W-1:0] idx_mask, widx, ridx, last_idx;
    logic [DATA_W-1:0] rdata;
    logic [STRB_W-1:0] rstrb, dp_strb;

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_valid <= 1'b0;
            dp       <= '0;
            dp_mst   <= '0;
        end else if (hready) begin
            dp_valid <= hsel && htrans[1] && hwrite;
            dp       <= '{addr: haddr, size: hsize};
            dp_mst   <= hmaster;
        end
    end

    wcb_nb_match i_nb (
        .addr   (dp.addr),
        .base   (cfg_nb_base),
        .size_n (cfg_nb_size),
        .hit    (nb_hit)
    );

    always_comb begin
        align    = cfg_line32 ? ~32'(LINE_B - 1) : ~32'(LINE_B / 2 - 1);
        idx_mask = cfg_line32 ? {IDX_W{1'b1}} : IDX_W'(LINE_WORDS / 2 - 1);
        bypass   = nb_hit || !cfg_comb_en[dp_mst];
        match    = line_valid && !line_single && ((dp.addr & align) == line_base);
        dp_strb  = lane_strobe(dp.addr[1:0], dp.size);
        widx     = bypass ? '0 : (dp.addr[IDX_W+1:2] & idx_mask);
        if (busy)
            can_take = 1'b0;
        else if (bypass)
            can_take = !line_valid;
        else
            can_take = !line_valid || (match && !full);
        accept   = dp_valid && can_take;
        hready   = !dp_valid || can_take;
        trigger  = line_valid && (line_single || full || tmo_hit || (dp_valid && !can_take));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_valid  <= 1'b0;
            line_single <= 1'b0;
            line_base   <= '0;
        end else if (done) begin
            line_valid  <= 1'b0;
        end else if (accept) begin
            line_valid <= 1'b1;
            if (!line_valid) begin
                line_single <= bypass;
                line_base   <= bypass ? {dp.addr[31:2], 2'b00} : (dp.addr & align);
            end
        end
    end

    wcb_line_store #(.WORDS(LINE_WORDS)) i_store (
        .clk   (clk),
        .rst   (rst),
        .clr   (done),
        .we    (accept),
        .widx  (widx),
        .wdata (hwdata),
        .wstrb (dp_strb),
        .wide  (cfg_line32),
        .ridx  (ridx),
        .rdata (rdata),
        .rstrb (rstrb),
        .full  (full)
    );

    wcb_timeout #(.W(TMO_W)) i_tmo (
        .clk   (clk),
        .rst   (rst),
        .clear (accept || !line_valid),
        .run   (line_valid && !busy),
        .limit (cfg_timeout),
        .count (tmo_cnt),
        .hit   (tmo_hit)
    );

    always_comb begin
        if (line_single)     awlen = 8'd0;
        else if (cfg_line32) awlen = 8'(LINE_WORDS - 1);
        else                 awlen = 8'(LINE_WORDS / 2 - 1);
        last_idx = awlen[IDX_W-1:0];
    end

    assign awaddr  = line_base;
    assign awsize  = 3'd2;
    assign awburst = 2'b01;

    wcb_flush_ctl #(.WORDS(LINE_WORDS)) i_flush (
        .clk       (clk),
        .rst       (rst),
        .trigger   (trigger),
        .gnt       (flush_gnt),
        .last_idx  (last_idx),
        .awready   (awready),
        .wready    (wready),
        .bvalid    (bvalid),
        .rdata     (rdata),
        .rstrb     (rstrb),
        .flush_req (flush_req),
        .busy      (busy),
        .done      (done),
        .b_out     (b_out),
        .awvalid   (awvalid),
        .wvalid    (wvalid),
        .wdata     (wdata),
        .wstrb     (wstrb),
        .wlast     (wlast),
        .bready    (bready),
        .ridx      (ridx)
    );
endmodule

// File: rtl/wcb_checker.sv
module wcb_checker (
    input logic        clk,
    input logic        rst,
    input logic        flush_req,
    input logic        flush_gnt,
    input logic        b_out,
    input logic        awvalid,
    input logic        awready,
    input logic [31:0] awaddr,
    input logic [7:0]  awlen,
    input logic [2:0]  awsize,
    input logic [1:0]  awburst,
    input logic        wvalid,
    input logic        wready,
    input logic        wlast,
    input logic        line_valid,
    input logic [9:0]  tmo_cnt,
    input logic [9:0]  cfg_timeout
);
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        flush_req && !flush_gnt |=> flush_req);

    assert_req_no_resp_R5: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> !b_out);

    assert_burst_shape_R1: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> (awburst == 2'b01 && awsize == 3'd2 &&
                     (awlen == 8'd0 || awlen == 8'd3 || awlen == 8'd7)));

    assert_aw_stable_R1: assert property (@(posedge clk) disable iff (rst)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));

    assert_w_ends_R1: assert property (@(posedge clk) disable iff (rst)
        wvalid && wready && wlast |=> !wvalid);

    assert_tmo_empty_R3: assert property (@(posedge clk) disable iff (rst)
        !line_valid |=> tmo_cnt == 10'd0);

    assert_tmo_bound_R3: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> tmo_cnt <= cfg_timeout);
endmodule

bind wcb_top wcb_checker i_wcb_checker (
    .clk         (clk),
    .rst         (rst),
    .flush_req   (flush_req),
    .flush_gnt   (flush_gnt),
    .b_out       (b_out),
    .awvalid     (awvalid),
    .awready     (awready),
    .awaddr      (awaddr),
    .awlen       (awlen),
    .awsize      (awsize),
    .awburst     (awburst),
    .wvalid      (wvalid),
    .wready      (wready),
    .wlast       (wlast),
    .line_valid  (line_valid),
    .tmo_cnt     (tmo_cnt),
    .cfg_timeout (cfg_timeout)
);

// File: tb/test_wcb_top.sv
module test_wcb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = '0;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = '0;
    logic [31:0] hwdata = '0;
    logic [1:0]  hmaster = '0;
    logic        hready;
    logic [9:0]  cfg_timeout = 10'd1000;
    logic        cfg_line32 = 1'b0;
    logic [15:0] cfg_nb_base = '0;
    logic [3:0]  cfg_nb_size = '0;
    logic [3:0]  cfg_comb_en = 4'b1111;
    logic        flush_req;
    logic        flush_gnt = 1'b0;
    logic        awvalid;
    logic        awready = 1'b1;
    logic [31:0] awaddr;
    logic [7:0]  awlen;
    logic [2:0]  awsize;
    logic [1:0]  awburst;
    logic        wvalid;
    logic        wready = 1'b1;
    logic [31:0] wdata;
    logic [3:0]  wstrb;
    logic        wlast;
    logic        bvalid = 1'b0;
    logic        bready;

    always #2.5 clk = ~clk;

    wcb_top i_wcb_top (.*);

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int last_acc = 0;
    int rise_cyc = -1;
    int b_delay  = 2;
    int b_timer  = 0;
    bit b_pending = 0;
    int req_viol = 0;
    bit prev_req = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- expected-burst scoreboard ----------------
    typedef struct {
        logic [31:0] addr;
        int          len;
        logic [31:0] d [8];
        logic [3:0]  s [8];
        string       tag;
    } exp_t;
    exp_t q[$];

    // bench line model built from the requirements
    bit          m_valid = 0;
    logic [31:0] m_base;
    logic [31:0] m_d [8];
    logic [3:0]  m_s [8];
    string       m_tag = "R1";

    function automatic logic [3:0] strobe_of(input logic [31:0] a, input logic [2:0] sz);
        if (sz == 3'd0) return 4'(1 << a[1:0]);
        if (sz == 3'd1) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic bit in_window(input logic [31:0] a);
        int sh;
        if (cfg_nb_size == 0) return 0;
        sh = int'(cfg_nb_size) + 15;
        return (a >> sh) == ({cfg_nb_base, 16'h0000} >> sh);
    endfunction

    function automatic void model_flush();
        exp_t e;
        if (!m_valid) return;
        e.addr = m_base;
        e.len  = cfg_line32 ? 7 : 3;
        for (int i = 0; i < 8; i++) begin e.d[i] = m_d[i]; e.s[i] = m_s[i]; end
        e.tag = m_tag;
        q.push_back(e);
        m_valid = 0;
    endfunction

    function automatic void model_write(input logic [31:0] a, input logic [2:0] sz,
                                        input logic [31:0] d, input logic [1:0] m, input string tag);
        logic [3:0]  s;
        logic [31:0] base;
        int          idx;
        int          words;
        bit          all;
        exp_t        e;
        s = strobe_of(a, sz);
        words = cfg_line32 ? 8 : 4;
        if (in_window(a) || !cfg_comb_en[m]) begin
            model_flush();
            e.addr = {a[31:2], 2'b00};
            e.len  = 0;
            for (int i = 0; i < 8; i++) begin e.d[i] = '0; e.s[i] = '0; end
            e.d[0] = d; e.s[0] = s; e.tag = tag;
            q.push_back(e);
            return;
        end
        base = a & ~(32'(words * 4) - 32'd1);
        if (m_valid && base != m_base) model_flush();
        if (!m_valid) begin
            m_valid = 1; m_base = base; m_tag = tag;
            for (int i = 0; i < 8; i++) begin m_d[i] = '0; m_s[i] = '0; end
        end
        idx = int'((a - base) >> 2);
        for (int b = 0; b < 4; b++)
            if (s[b]) m_d[idx][8*b +: 8] = d[8*b +: 8];
        m_s[idx] = m_s[idx] | s;
        all = 1;
        for (int i = 0; i < words; i++) if (m_s[i] != 4'hF) all = 0;
        if (all) model_flush();
    endfunction

    // ---------------- monitor, arbiter and AXI slave ----------------
    logic [31:0] got_addr;
    int          got_len;
    logic [31:0] got_d [8];
    logic [3:0]  got_s [8];
    int          got_n = 0;

    task automatic compare_burst();
        exp_t e;
        bit ok;
        logic [31:0] act, expv;
        if (q.size() == 0) begin
            check(0, "R1 unexpected burst", got_addr, 32'h0);
            return;
        end
        e = q.pop_front();
        ok = 1; act = '0; expv = '0;
        if (got_addr != e.addr) begin ok = 0; act = got_addr; expv = e.addr; end
        else if (got_len != e.len || got_n != e.len + 1) begin
            ok = 0; act = 32'(got_n - 1); expv = 32'(e.len);
        end else begin
            for (int i = 0; i <= e.len; i++) begin
                if (ok && got_s[i] != e.s[i]) begin
                    ok = 0; act = 32'(got_s[i]); expv = 32'(e.s[i]);
                end
                for (int b = 0; b < 4; b++)
                    if (ok && e.s[i][b] && got_d[i][8*b +: 8] != e.d[i][8*b +: 8]) begin
                        ok = 0; act = got_d[i]; expv = e.d[i];
                    end
            end
        end
        check(ok, {e.tag, " burst content"}, act, expv);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (flush_req && b_pending) req_viol++;
            if (flush_req && !prev_req) rise_cyc = cyc;
            prev_req = flush_req;
            flush_gnt <= flush_req;
            if (awvalid && awready) begin
                got_addr = awaddr; got_len = int'(awlen); got_n = 0;
            end
            if (wvalid && wready) begin
                if (got_n < 8) begin got_d[got_n] = wdata; got_s[got_n] = wstrb; end
                got_n++;
                if (wlast) compare_burst();
            end
            if (bvalid) begin
                bvalid <= 1'b0; b_pending = 0;
            end else if (b_timer > 0) begin
                b_timer--;
                if (b_timer == 0) bvalid <= 1'b1;
            end
            if (wvalid && wready && wlast) begin
                b_pending = 1; b_timer = b_delay;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic ahb_wr(input logic [31:0] a, input logic [2:0] sz, input logic [31:0] d,
                          input logic [1:0] m, input string tag, output int stalls);
        model_write(a, sz, d, m, tag);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = a; hsize = sz; hmaster = m;
        while (!hready) @(negedge clk);
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = d;
        stalls = 0;
        while (!hready) begin stalls++; @(negedge clk); end
        @(negedge clk);
        last_acc = cyc;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while ((q.size() != 0 || b_pending || bvalid || m_valid_rtl_pending()) && n < 4000) begin
            @(negedge clk); n++;
        end
        repeat (4) @(negedge clk);
        check(q.size() == 0, {tag, " all expected bursts seen"}, 32'(q.size()), 32'd0);
    endtask

    function automatic bit m_valid_rtl_pending();
        return 0;
    endfunction

    int st;

    initial begin
        repeat (2000000) @(posedge clk);
        check(0, "watchdog expired", 32'(cyc), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(hready == 1'b1,    "R9 hready after reset",    32'(hready),    32'd1);
        check(flush_req == 1'b0, "R9 flush_req after reset", 32'(flush_req), 32'd0);
        check(awvalid == 1'b0,   "R9 awvalid after reset",   32'(awvalid),   32'd0);
        check(wvalid == 1'b0,    "R9 wvalid after reset",    32'(wvalid),    32'd0);

        // R1 / R4: 16-byte line filled in ascending order, long timeout
        cfg_line32 = 1'b0; cfg_timeout = 10'd1000;
        for (int i = 0; i < 4; i++)
            ahb_wr(32'h0000_1000 + 32'(4 * i), 3'd2, 32'hA000_0000 + 32'(i), 2'd0, "R1 R4 16B", st);
        repeat (15) @(negedge clk);
        check(q.size() == 0, "R4 full line left before timeout", 32'(q.size()), 32'd0);

        // R2 / R10 / R3: partial line with mixed sizes, then idle timeout
        cfg_timeout = 10'd15;
        ahb_wr(32'h0000_2001, 3'd0, 32'h0000_AB00, 2'd0, "R2 R10 lanes", st);
        repeat (10) @(negedge clk);
        ahb_wr(32'h0000_2006, 3'd1, 32'hCDEF_0000, 2'd0, "R2", st);
        ahb_wr(32'h0000_2008, 3'd2, 32'h1122_3344, 2'd0, "R2", st);
        rise_cyc = -1;
        ahb_wr(32'h0000_2009, 3'd0, 32'h0000_5500, 2'd0, "R10", st);
        check(flush_req == 1'b0, "R3 no request right after write", 32'(flush_req), 32'd0);
        model_flush();
        drain("R3");
        check(rise_cyc - last_acc == 16, "R3 timeout latency", 32'(rise_cyc - last_acc), 32'd16);

        // R1: 32-byte line, descending order
        cfg_line32 = 1'b1; cfg_timeout = 10'd1000;
        for (int i = 7; i >= 0; i--)
            ahb_wr(32'h0000_3000 + 32'(4 * i), 3'd2, 32'hB000_0000 + 32'(i), 2'd1, "R1 32B", st);
        drain("R1 32B");

        // R6: write to a different line
        cfg_line32 = 1'b0; cfg_timeout = 10'd40;
        ahb_wr(32'h0000_4004, 3'd2, 32'hC0C0_C0C0, 2'd0, "R6 first line", st);
        ahb_wr(32'h0000_5000, 3'd2, 32'hD0D0_D0D0, 2'd0, "R6 second line", st);
        check(st > 0, "R6 hready stalled on line conflict", 32'(st), 32'd1);
        model_flush();
        drain("R6");

        // R7: non-bufferable window, N=1 (64 KB at 0x8000_0000)
        cfg_nb_base = 16'h8000; cfg_nb_size = 4'd1;
        ahb_wr(32'h0000_6000, 3'd2, 32'h6666_0000, 2'd0, "R7 held line", st);
        ahb_wr(32'h8000_0010, 3'd2, 32'h7777_0001, 2'd0, "R7 inside window", st);
        check(st > 0, "R7 window write waits for line flush", 32'(st), 32'd1);
        ahb_wr(32'h8001_0000, 3'd2, 32'h7777_0002, 2'd0, "R7 outside window", st);
        model_flush();
        drain("R7 N=1");
        // N=4: 512 KB window
        cfg_nb_size = 4'd4;
        ahb_wr(32'h8007_0004, 3'd1, 32'h0000_1234, 2'd0, "R7 inside N=4", st);
        ahb_wr(32'h8008_0000, 3'd2, 32'h7777_0003, 2'd0, "R7 outside N=4", st);
        model_flush();
        drain("R7 N=4");
        cfg_nb_size = 4'd0;

        // R8: combining disabled for master 2
        cfg_comb_en = 4'b1011;
        ahb_wr(32'h0000_7000, 3'd2, 32'h8888_0000, 2'd2, "R8 disabled master", st);
        ahb_wr(32'h0000_7008, 3'd2, 32'h8888_0001, 2'd1, "R8 enabled master", st);
        ahb_wr(32'h0000_700C, 3'd2, 32'h8888_0002, 2'd2, "R8 disabled master after line", st);
        model_flush();
        drain("R8");
        cfg_comb_en = 4'b1111;

        // R5: slow write response, short timeout
        b_delay = 40; cfg_timeout = 10'd2; req_viol = 0;
        for (int i = 0; i < 3; i++) begin
            ahb_wr(32'h0000_9000 + 32'(16 * i), 3'd2, 32'h9999_0000 + 32'(i), 2'd0, "R5", st);
            model_flush();
        end
        drain("R5");
        check(req_viol == 0, "R5 request while response outstanding", 32'(req_viol), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule